// File: doc/BRIEF.md
# Paired Word FIFOs with Programmable Fill Thresholds

This block holds two synchronous word FIFOs, one for the transmit direction and one for the receive direction of a serial slave port. Each FIFO takes words on a valid/ready input stream and delivers them on a valid/ready output stream. A push happens in a cycle where `*_in_valid` and `*_in_ready` are both high. A pop happens in a cycle where `*_out_valid` and `*_out_ready` are both high. A producer that sees `*_in_ready` low must hold its word, and a consumer sees the head word on `*_out_data` whenever `*_out_valid` is high. A consumer that asserts ready against an empty FIFO, or a producer that asserts valid against a full one, is refused. The refusal is reported and has no other effect.

Each direction has one 32-bit threshold register. Its upper half sets the programmable-empty level and its lower half sets the programmable-full level. A 13-bit status word gathers the empty, full, programmable-empty and programmable-full flags of both FIFOs, a sticky overflow bit and a sticky underflow bit for each FIFO, and the synchronised level of the active-low slave-select pin. A soft-clear strobe empties both FIFOs and clears the sticky error bits. It leaves the thresholds as they are, so software can recover from an underflow without a full reset. Depth is 2^`DEPTH_LOG2` words, with `DEPTH_LOG2` from 4 to 7.

Top module: `lvl_fifo_pair`

## Requirements
- R1: After reset, `status` reads 13'h1145. That value has empty and programmable-empty set for both directions, the slave-select bit set, and every other bit zero. After reset both `*_in_ready` are high and both `*_out_valid` are low. The thresholds reset to programmable-empty 0 and programmable-full DEPTH.
- R2: Each FIFO returns words in the order it accepted them. A push and a pop in the same cycle are both honoured. While `*_out_valid` is high and no pop occurs, `*_out_data` holds its value.
- R3: The status layout is fixed. Bits [5:0] belong to the transmit FIFO and bits [11:6] to the receive FIFO. Within each 6-bit group, bit 0 is empty, bit 1 full, bit 2 programmable-empty, bit 3 programmable-full, bit 4 sticky overflow and bit 5 sticky underflow. Empty means a count of 0 and full means a count of DEPTH. `*_in_ready` equals not-full and `*_out_valid` equals not-empty.
- R4: Programmable-empty is set when the word count is at or below bits [31:16] of that direction's threshold register.
- R5: Programmable-full is set when the word count is at or above bits [15:0] of that direction's threshold register. A write with `cfg_we` high loads `cfg_wdata` into the transmit register when `cfg_sel` is 0 and into the receive register when `cfg_sel` is 1. The new levels take effect on the flags one cycle after the write.
- R6: A cycle with `*_in_valid` high while the FIFO is full stores nothing and leaves the count unchanged. The following cycle, that FIFO's `*_ovf_pulse` is high for one cycle and its sticky overflow bit is set.
- R7: A cycle with `*_out_ready` high while the FIFO is empty changes nothing. The following cycle, that FIFO's `*_udf_pulse` is high for one cycle and its sticky underflow bit is set.
- R8: In the cycle after `soft_clr` is high, both FIFOs are empty and both sticky bits of each direction are clear. Programmable-empty and programmable-full are re-evaluated for a count of 0, which returns them to their reset values for any nonzero programmable-full level. The thresholds keep their values, and any push or pop in the clearing cycle is discarded.
- R9: Status bit 12 follows `ss_n` through two flip-flops, so it shows the pin level two rising edges after the pin changes.
- R10: The flags are registered. A push or pop at a rising edge is reflected in the flags, `*_in_ready` and `*_out_valid` right after that same edge. For example, one push into an empty FIFO whose programmable-empty level is at least 1 clears empty while programmable-empty stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of both FIFOs and their sticky errors |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_sel | input | 1 | Threshold register select: 0 transmit, 1 receive |
| cfg_wdata | input | 32 | Threshold value: [31:16] programmable-empty, [15:0] programmable-full |
| ss_n | input | 1 | Active-low slave-select pin, asynchronous |
| tx_in_valid | input | 1 | Transmit FIFO input valid |
| tx_in_ready | output | 1 | Transmit FIFO can accept a word |
| tx_in_data | input | DW | Transmit FIFO input word |
| tx_out_valid | output | 1 | Transmit FIFO head word valid |
| tx_out_ready | input | 1 | Transmit FIFO consumer takes the head word |
| tx_out_data | output | DW | Transmit FIFO head word |
| rx_in_valid | input | 1 | Receive FIFO input valid |
| rx_in_ready | output | 1 | Receive FIFO can accept a word |
| rx_in_data | input | DW | Receive FIFO input word |
| rx_out_valid | output | 1 | Receive FIFO head word valid |
| rx_out_ready | input | 1 | Receive FIFO consumer takes the head word |
| rx_out_data | output | DW | Receive FIFO head word |
| tx_ovf_pulse | output | 1 | Transmit push refused in the previous cycle |
| tx_udf_pulse | output | 1 | Transmit pop refused in the previous cycle |
| rx_ovf_pulse | output | 1 | Receive push refused in the previous cycle |
| rx_udf_pulse | output | 1 | Receive pop refused in the previous cycle |
| status | output | 13 | Packed flag word, layout in R3 and R9 |

## Verification
Push, pop, refusal and soft-clear effects are all due one edge after the stimulus. The exception is a threshold write: the register loads at the first edge and the flags use the new level at the second. The slave-select bit is due two edges after the pin moves. The bench drives inputs on the falling edge and advances its reference model at the rising edge, using the pre-edge threshold and flag state exactly as the requirements describe. It then compares every output at the next falling edge, so each result is sampled in precisely the cycle it falls due.

// File: rtl/lvl_fifo_pkg.sv
`timescale 1ns/1ps
package lvl_fifo_pkg;

  localparam int THR_W    = 16;
  localparam int DIR_W    = 6;
  localparam int STATUS_W = 2 * DIR_W + 1;

  // Bit 0 is the LSB: empty, full, pempty, pfull, ovf, udf.
  typedef struct packed {
    logic udf;
    logic ovf;
    logic pfull;
    logic pempty;
    logic full;
    logic empty;
  } dir_flags_t;

  function automatic logic [THR_W-1:0] thr_empty_lvl(input logic [31:0] word);
    return word[31:16];
  endfunction

  function automatic logic [THR_W-1:0] thr_full_lvl(input logic [31:0] word);
    return word[15:0];
  endfunction

endpackage

// File: rtl/lvl_thr_regs.sv
`timescale 1ns/1ps
module lvl_thr_regs
  import lvl_fifo_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [THR_W-1:0] tx_pe_lvl,
  output logic [THR_W-1:0] tx_pf_lvl,
  output logic [THR_W-1:0] rx_pe_lvl,
  output logic [THR_W-1:0] rx_pf_lvl
);

  localparam int NDIR = 2;
  localparam logic [THR_W-1:0] PF_RESET = THR_W'(1 << DEPTH_LOG2);

  logic [THR_W-1:0] pe_q [NDIR];
  logic [THR_W-1:0] pf_q [NDIR];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pe_q[d] <= '0;
        pf_q[d] <= PF_RESET;
      end else if (cfg_we && (cfg_sel == 1'(d))) begin
        pe_q[d] <= thr_empty_lvl(cfg_wdata);
        pf_q[d] <= thr_full_lvl(cfg_wdata);
      end
    end
  end

  assign tx_pe_lvl = pe_q[0];
  assign tx_pf_lvl = pf_q[0];
  assign rx_pe_lvl = pe_q[1];
  assign rx_pf_lvl = pf_q[1];

endmodule

// File: rtl/lvl_pin_sync.sv
`timescale 1ns/1ps
module lvl_pin_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], pin};
  end

  assign level = chain_q[STAGES-1];

endmodule

// File: rtl/lvl_fifo_core.sv
`timescale 1ns/1ps
module lvl_fifo_core
  import lvl_fifo_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  input  logic [THR_W-1:0] pe_lvl,
  input  logic [THR_W-1:0] pf_lvl,
  output dir_flags_t       flags,
  output logic             ovf_pulse,
  output logic             udf_pulse
);

  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nx;
  dir_flags_t    flg_q;

  logic push, pop, push_refused, pop_refused;
  logic [THR_W-1:0] cnt_nx_ext;

  assign push         = in_valid  && !flg_q.full;
  assign pop          = out_ready && !flg_q.empty;
  assign push_refused = in_valid  &&  flg_q.full;
  assign pop_refused  = out_ready &&  flg_q.empty;

  always_comb begin
    cnt_nx = cnt;
    if (push) cnt_nx = cnt_nx + CW'(1);
    if (pop)  cnt_nx = cnt_nx - CW'(1);
  end

  assign cnt_nx_ext = THR_W'(cnt_nx);

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      cnt          <= '0;
      flg_q.empty  <= 1'b1;
      flg_q.full   <= 1'b0;
      flg_q.pempty <= 1'b1;
      flg_q.pfull  <= 1'b0;
      flg_q.ovf    <= 1'b0;
      flg_q.udf    <= 1'b0;
      ovf_pulse    <= 1'b0;
      udf_pulse    <= 1'b0;
    end else if (clr) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      cnt          <= '0;
      flg_q.empty  <= 1'b1;
      flg_q.full   <= 1'b0;
      flg_q.pempty <= 1'b1;
      flg_q.pfull  <= (pf_lvl == '0);
      flg_q.ovf    <= 1'b0;
      flg_q.udf    <= 1'b0;
      ovf_pulse    <= 1'b0;
      udf_pulse    <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      cnt          <= cnt_nx;
      flg_q.empty  <= (cnt_nx == '0);
      flg_q.full   <= (cnt_nx == CNT_FULL);
      flg_q.pempty <= (cnt_nx_ext <= pe_lvl);
      flg_q.pfull  <= (cnt_nx_ext >= pf_lvl);
      flg_q.ovf    <= flg_q.ovf | push_refused;
      flg_q.udf    <= flg_q.udf | pop_refused;
      ovf_pulse    <= push_refused;
      udf_pulse    <= pop_refused;
    end
  end

  assign in_ready  = !flg_q.full;
  assign out_valid = !flg_q.empty;
  assign out_data  = mem[rd_ptr];
  assign flags     = flg_q;

endmodule

// File: rtl/lvl_fifo_pair.sv
`timescale 1ns/1ps
module lvl_fifo_pair
  import lvl_fifo_pkg::*;
#(
  parameter int DW         = 32,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_clr,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [31:0]         cfg_wdata,
  input  logic                ss_n,
  input  logic                tx_in_valid,
  output logic                tx_in_ready,
  input  logic [DW-1:0]       tx_in_data,
  output logic                tx_out_valid,
  input  logic                tx_out_ready,
  output logic [DW-1:0]       tx_out_data,
  input  logic                rx_in_valid,
  output logic                rx_in_ready,
  input  logic [DW-1:0]       rx_in_data,
  output logic                rx_out_valid,
  input  logic                rx_out_ready,
  output logic [DW-1:0]       rx_out_data,
  output logic                tx_ovf_pulse,
  output logic                tx_udf_pulse,
  output logic                rx_ovf_pulse,
  output logic                rx_udf_pulse,
  output logic [STATUS_W-1:0] status
);

  logic [THR_W-1:0] tx_pe_lvl, tx_pf_lvl, rx_pe_lvl, rx_pf_lvl;
  dir_flags_t       tx_flags, rx_flags;
  logic             ss_level;

  lvl_thr_regs #(.DEPTH_LOG2(DEPTH_LOG2)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tx_pe_lvl (tx_pe_lvl),
    .tx_pf_lvl (tx_pf_lvl),
    .rx_pe_lvl (rx_pe_lvl),
    .rx_pf_lvl (rx_pf_lvl)
  );

  lvl_pin_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_ss (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ss_n),
    .level (ss_level)
  );

  lvl_fifo_core #(.DW(DW), .AW(DEPTH_LOG2)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .pe_lvl    (tx_pe_lvl),
    .pf_lvl    (tx_pf_lvl),
    .flags     (tx_flags),
    .ovf_pulse (tx_ovf_pulse),
    .udf_pulse (tx_udf_pulse)
  );

  lvl_fifo_core #(.DW(DW), .AW(DEPTH_LOG2)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (rx_in_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .pe_lvl    (rx_pe_lvl),
    .pf_lvl    (rx_pf_lvl),
    .flags     (rx_flags),
    .ovf_pulse (rx_ovf_pulse),
    .udf_pulse (rx_udf_pulse)
  );

  assign status = {ss_level, rx_flags, tx_flags};

endmodule

// File: rtl/lvl_fifo_pair_chk.sv
`timescale 1ns/1ps
module lvl_fifo_pair_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_clr,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          rx_in_valid,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          tx_ovf_pulse,
  input logic          rx_udf_pulse,
  input logic [12:0]   status
);

  // R2: an unconsumed head word stays put
  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && !soft_clr) |=> $stable(tx_out_data));

  // R3: empty and full never together
  p_not_empty_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]) && !(status[6] && status[7]));

  // R6: refused push gives pulse and sticky bit
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready && !soft_clr) |=> (tx_ovf_pulse && status[4]));

  // R7: refused pop on receive side gives pulse and sticky bit
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_ready && !rx_out_valid && !soft_clr) |=> (rx_udf_pulse && status[11]));

  // R8: soft clear empties both and drops sticky errors
  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status[0] && status[6] && status[2] && status[8] &&
                  !status[4] && !status[5] && !status[10] && !status[11]));

  // R8: nothing can be popped right after a clear
  p_clear_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!tx_out_valid && !rx_out_valid));

  // R6: the pulse is a single cycle unless the refusal repeats
  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_pulse && !(tx_in_valid && !tx_in_ready)) |=> !tx_ovf_pulse);

endmodule

bind lvl_fifo_pair lvl_fifo_pair_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_lvl_fifo_pair.sv
`timescale 1ns/1ps
module sim_lvl_fifo_pair;

  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic ss_n = 1'b1;

  logic          iv   [2];
  logic          ordy [2];
  logic [DW-1:0] idat [2];
  logic          irdy [2];
  logic          ovld [2];
  logic [DW-1:0] odat [2];
  logic          opul [2];
  logic          upul [2];
  logic [12:0]   status;

  always #10 clk = ~clk;

  lvl_fifo_pair #(.DW(DW), .DEPTH_LOG2(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ss_n(ss_n),
    .tx_in_valid(iv[0]), .tx_in_ready(irdy[0]), .tx_in_data(idat[0]),
    .tx_out_valid(ovld[0]), .tx_out_ready(ordy[0]), .tx_out_data(odat[0]),
    .rx_in_valid(iv[1]), .rx_in_ready(irdy[1]), .rx_in_data(idat[1]),
    .rx_out_valid(ovld[1]), .rx_out_ready(ordy[1]), .rx_out_data(odat[1]),
    .tx_ovf_pulse(opul[0]), .tx_udf_pulse(upul[0]),
    .rx_ovf_pulse(opul[1]), .rx_udf_pulse(upul[1]),
    .status(status)
  );

  // reference model
  logic [DW-1:0] mq [2][DEPTH];
  int  mcnt [2], mhead [2], mpe [2], mpf [2];
  bit  me [2], mf [2], mpem [2], mpfl [2], mov [2], mud [2], mop [2], mup [2];
  bit  s1, s2;

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      mcnt[d] = 0; mhead[d] = 0; mpe[d] = 0; mpf[d] = DEPTH;
      me[d] = 1; mf[d] = 0; mpem[d] = 1; mpfl[d] = 0;
      mov[d] = 0; mud[d] = 0; mop[d] = 0; mup[d] = 0;
    end
    s1 = 1; s2 = 1;
  endtask

  task automatic model_edge();
    for (int d = 0; d < 2; d++) begin
      if (soft_clr) begin
        mcnt[d] = 0; mhead[d] = 0;
        mov[d] = 0; mud[d] = 0; mop[d] = 0; mup[d] = 0;
      end else begin
        bit psh, pp;
        psh = iv[d] && !mf[d];
        pp  = ordy[d] && !me[d];
        mop[d] = iv[d] && mf[d];
        mup[d] = ordy[d] && me[d];
        mov[d] = mov[d] | mop[d];
        mud[d] = mud[d] | mup[d];
        if (psh) mq[d][(mhead[d] + mcnt[d]) % DEPTH] = idat[d];
        if (pp)  mhead[d] = (mhead[d] + 1) % DEPTH;
        mcnt[d] = mcnt[d] + int'(psh) - int'(pp);
      end
      me[d]   = (mcnt[d] == 0);
      mf[d]   = (mcnt[d] == DEPTH);
      mpem[d] = (mcnt[d] <= mpe[d]);
      mpfl[d] = (mcnt[d] >= mpf[d]);
    end
    if (cfg_we) begin
      mpe[cfg_sel] = int'(cfg_wdata[31:16]);
      mpf[cfg_sel] = int'(cfg_wdata[15:0]);
    end
    s2 = s1; s1 = ss_n;
  endtask

  task automatic check_all();
    for (int d = 0; d < 2; d++) begin
      int b;
      b = 6 * d;
      chk(status[b+0] == me[d],   "R3 empty flag",  status[b+0], me[d]);
      chk(status[b+1] == mf[d],   "R3 full flag",   status[b+1], mf[d]);
      chk(irdy[d] == !mf[d],      "R3 in_ready",    irdy[d], !mf[d]);
      chk(ovld[d] == !me[d],      "R3 out_valid",   ovld[d], !me[d]);
      chk(status[b+2] == mpem[d], "R4 prog empty",  status[b+2], mpem[d]);
      chk(status[b+3] == mpfl[d], "R5 prog full",   status[b+3], mpfl[d]);
      chk(status[b+4] == mov[d],  "R6 sticky ovf",  status[b+4], mov[d]);
      chk(opul[d] == mop[d],      "R6 ovf pulse",   opul[d], mop[d]);
      chk(status[b+5] == mud[d],  "R7 sticky udf",  status[b+5], mud[d]);
      chk(upul[d] == mup[d],      "R7 udf pulse",   upul[d], mup[d]);
      if (!me[d])
        chk(odat[d] == mq[d][mhead[d]], "R2 head data", odat[d], mq[d][mhead[d]]);
    end
    chk(status[12] == s2, "R9 slave select", status[12], s2);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_inputs();
    for (int d = 0; d < 2; d++) begin
      iv[d] = 0; ordy[d] = 0; idat[d] = '0;
    end
    soft_clr = 0; cfg_we = 0;
  endtask

  task automatic write_thr(input bit sel, input int pe, input int pf);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = {16'(pe), 16'(pf)};
    step();
    cfg_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nchecks++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h51ed);
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(status == 13'h1145, "R1 reset status", status, 13'h1145);
    chk(irdy[0] && irdy[1] && !ovld[0] && !ovld[1], "R1 reset handshake",
        {irdy[0], irdy[1], ovld[0], ovld[1]}, 4'b1100);
    check_all();

    write_thr(0, 3, 10);
    write_thr(1, 5, 12);
    step();

    // R10: one push clears empty, pempty stays
    iv[0] = 1; idat[0] = 32'hA5A5_0001;
    step();
    iv[0] = 0;
    chk(!status[0] && status[2], "R10 flag after one push", status[2:0], 3'b100);

    // R6: fill transmit FIFO then push two more
    for (int i = 0; i < DEPTH + 1; i++) begin
      iv[0] = 1; idat[0] = 32'h1000 + i;
      step();
    end
    chk(status[1] && status[4] && opul[0], "R6 overflow seen", status[5:0], 6'h1a);
    iv[0] = 0;
    step();
    chk(!opul[0], "R6 pulse single", opul[0], 0);

    // R7: drain transmit FIFO past empty
    for (int i = 0; i < DEPTH + 2; i++) begin
      ordy[0] = 1;
      step();
    end
    ordy[0] = 0;
    chk(status[0] && status[5], "R7 underflow sticky", status[5:0], 6'h35);

    // R2: simultaneous push and pop on receive
    for (int i = 0; i < 20; i++) begin
      iv[1] = 1; idat[1] = 32'hBEEF_0000 + i; ordy[1] = (i > 2);
      step();
    end
    idle_inputs();

    // R9: slave select
    ss_n = 0; step(); step();
    chk(status[12] == 0, "R9 select low", status[12], 0);
    ss_n = 1; step(); step();

    // R8: soft clear with traffic present
    soft_clr = 1; iv[1] = 1; ordy[0] = 1;
    step();
    idle_inputs();
    chk(status[11:0] == 12'h145, "R8 after clear", status[11:0], 12'h145);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int bias;
      bias = (n / 500) % 2;
      for (int d = 0; d < 2; d++) begin
        iv[d]   = ($urandom % 100) < (bias ? 75 : 35);
        ordy[d] = ($urandom % 100) < (bias ? 35 : 75);
        idat[d] = $urandom;
      end
      soft_clr = ($urandom % 200) == 0;
      cfg_we   = ($urandom % 50) == 0;
      cfg_sel  = $urandom % 2;
      cfg_wdata = {16'($urandom % (DEPTH + 1)), 16'($urandom % (DEPTH + 2))};
      if (($urandom % 20) == 0) ss_n = ~ss_n;
      step();
    end
    idle_inputs();
    step();
    finish_run();
  end

endmodule